// File: doc/BRIEF.md
# Synchronous Burst Static RAM

This block models a clocked static RAM whose words are 18 bits wide, split into a lower and an upper 9-bit byte lane. Every control, address and data input is captured on the rising clock edge. A new base address enters through either of two address strobes. The host-side strobe always wins. The controller-side strobe applies only when the host-side strobe is idle.

After a load, a two-bit burst counter walks the four words that share the upper address bits. The burst-advance input either steps the counter or holds it, which inserts a wait state. The chip select is examined only when an address is loaded, and the whole burst uses the value captured then.

A host-side load always performs a read. A write can still follow it in the next cycle: both strobes are held idle and write data with lane enables is presented. Read data is registered, and output enable gates it onto the data-out port.

Top module: `burst_sram`

## Requirements
- R1: While reset is asserted and after it is released, data-out reads zero until an enabled read has been performed. Reset does not clear the stored words.
- R2: When host_ld_n is low, the address on addr is loaded and the access is a read, whatever we_n, ctlr_ld_n and the lane enables are doing. The word appears on dout after that same edge.
- R3: In the cycle right after a host load, with both strobes high and burst_go_n high, we_n low and a lane enable low, the lanes selected by the enables are written at the loaded address.
- R4: When ctlr_ld_n is low and host_ld_n is high, addr is loaded. The access is a write when we_n is low and at least one lane enable is low, and a read otherwise.
- R5: cs_n is sampled only in a load cycle, where low means enabled. A burst loaded while disabled writes nothing and reads as zero. A change of cs_n during later cycles of the burst has no effect.
- R6: With both strobes high and burst_go_n low, the burst count goes up by one before the access. The low two address bits are then the loaded low bits XOR the count, with the count cleared to 0 at load.
- R7: With both strobes high and burst_go_n high, the same word is accessed again. Such a held cycle writes nothing unless it is the cycle right after a host load.
- R8: The upper address bits never change during a burst, and the fourth step brings the address back to the loaded one.
- R9: lane_lo_n low writes bits 8:0 and lane_hi_n low writes bits 17:9. A lane whose enable is high keeps its stored bits.
- R10: dout is zero whenever oe_n is high. With oe_n low, dout shows the last read word if that read was enabled. oe_n acts without a clock edge.
- R11: With BURST_LINEAR set to 1, the low two address bits are the loaded low bits plus the count, modulo 4, instead of the XOR order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address, loaded by either strobe |
| host_ld_n | input | 1 | Host-side address strobe, active low, highest priority, forces a read |
| ctlr_ld_n | input | 1 | Controller-side address strobe, active low |
| burst_go_n | input | 1 | Burst advance, active low; high holds the address |
| cs_n | input | 1 | Chip select, active low, sampled at load only |
| we_n | input | 1 | Write enable, active low |
| lane_lo_n | input | 1 | Lower lane enable (bits 8:0), active low |
| lane_hi_n | input | 1 | Upper lane enable (bits 17:9), active low |
| oe_n | input | 1 | Output enable, active low, combinational |
| din | input | 2*LANE_W | Write data |
| dout | output | 2*LANE_W | Registered read data, gated by output enable |

## Verification
The bench builds two copies with ADDR_W set to 6 and LANE_W left at 9. This keeps the array small while leaving the upper address bits wide enough to tell separate bursts apart. The first copy keeps the default XOR burst order. It carries the table of vectors, which covers strobe priority, deferred writes, wait states, wrap-around and gating by the sampled chip select. The second copy sets BURST_LINEAR to 1 and takes the same stimulus. A burst started from an odd base address then shows the two orders splitting on their second word.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

   // Kind of array access chosen for the current cycle.
   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_e;

   localparam int unsigned BURST_BITS = 2;

endpackage

// File: rtl/sbr_ctrl.sv
module sbr_ctrl
   import sbr_pkg::*;
#(
   parameter int unsigned LANES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_ld_n,
   input  logic             ctlr_ld_n,
   input  logic             burst_go_n,
   input  logic             cs_n,
   input  logic             we_n,
   input  logic [LANES-1:0] lane_n,
   output logic             load_o,
   output logic             step_o,
   output logic             en_now_o,
   output logic             en_q_o,
   output logic             pend_q_o,
   output acc_e             acc_o
);

   logic host_ld;
   logic ctlr_ld;
   logic idle_strb;
   logic wr_req;
   logic en_q;
   logic pend_q;
   acc_e kind;

   // Host strobe has priority over the controller strobe.
   assign host_ld   = ~host_ld_n;
   assign ctlr_ld   = host_ld_n & ~ctlr_ld_n;
   assign idle_strb = host_ld_n & ctlr_ld_n;
   assign wr_req    = ~we_n & (|(~lane_n));

   assign load_o   = host_ld | ctlr_ld;
   assign step_o   = idle_strb & ~burst_go_n;
   assign en_now_o = load_o ? ~cs_n : en_q;

   always_comb begin
      if (host_ld) begin
         kind = ACC_READ;
      end else if (ctlr_ld) begin
         kind = wr_req ? ACC_WRITE : ACC_READ;
      end else if (wr_req && (step_o || pend_q)) begin
         kind = ACC_WRITE;
      end else begin
         kind = ACC_READ;
      end
   end

   // A write to a disabled device becomes no access at all.
   assign acc_o = (kind == ACC_WRITE && !en_now_o) ? ACC_NONE : kind;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         en_q   <= en_now_o;
         pend_q <= host_ld;
      end
   end

   assign en_q_o   = en_q;
   assign pend_q_o = pend_q;

endmodule

// File: rtl/sbr_burst.sv
module sbr_burst
   import sbr_pkg::*;
#(
   parameter int unsigned ADDR_W       = 8,
   parameter bit          BURST_LINEAR = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic                  step,
   input  logic [ADDR_W-1:0]     addr_i,
   output logic [ADDR_W-1:0]     addr_o,
   output logic [BURST_BITS-1:0] cnt_o
);

   localparam int unsigned HI_W = ADDR_W - BURST_BITS;

   logic [ADDR_W-1:0]     base_q;
   logic [ADDR_W-1:0]     base_nx;
   logic [BURST_BITS-1:0] cnt_q;
   logic [BURST_BITS-1:0] cnt_nx;
   logic [BURST_BITS-1:0] low_bits;

   always_comb begin
      if (load) begin
         cnt_nx = '0;
      end else if (step) begin
         cnt_nx = cnt_q + BURST_BITS'(1);
      end else begin
         cnt_nx = cnt_q;
      end
   end

   assign base_nx = load ? addr_i : base_q;

   generate
      if (BURST_LINEAR) begin : g_linear
         assign low_bits = base_nx[BURST_BITS-1:0] + cnt_nx;
      end else begin : g_xor
         assign low_bits = base_nx[BURST_BITS-1:0] ^ cnt_nx;
      end
   endgenerate

   assign addr_o = {base_nx[ADDR_W-1 -: HI_W], low_bits};
   assign cnt_o  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
      end else begin
         base_q <= base_nx;
         cnt_q  <= cnt_nx;
      end
   end

endmodule

// File: rtl/sbr_array.sv
module sbr_array #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned LANE_W = 9,
   parameter int unsigned LANES  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr,
   input  logic                    rd,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES-1:0]        lane_we,
   input  logic [LANES*LANE_W-1:0] din,
   output logic [LANES*LANE_W-1:0] rdata
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [LANE_W-1:0] mem_q [DEPTH];
         logic [LANE_W-1:0] rd_q;

         always_ff @(posedge clk) begin
            if (wr && lane_we[g]) begin
               mem_q[addr] <= din[g*LANE_W +: LANE_W];
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rd_q <= '0;
            end else if (rd) begin
               rd_q <= mem_q[addr];
            end
         end

         assign rdata[g*LANE_W +: LANE_W] = rd_q;
      end
   endgenerate

endmodule

// File: rtl/burst_sram.sv
module burst_sram
   import sbr_pkg::*;
#(
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned LANE_W       = 9,
   parameter bit          BURST_LINEAR = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     addr,
   input  logic                  host_ld_n,
   input  logic                  ctlr_ld_n,
   input  logic                  burst_go_n,
   input  logic                  cs_n,
   input  logic                  we_n,
   input  logic                  lane_lo_n,
   input  logic                  lane_hi_n,
   input  logic                  oe_n,
   input  logic [2*LANE_W-1:0]   din,
   output logic [2*LANE_W-1:0]   dout
);

   localparam int unsigned LANES  = 2;
   localparam int unsigned DATA_W = LANES * LANE_W;

   generate
      if (ADDR_W < BURST_BITS || ADDR_W > 12) begin : g_bad_addr_w
         $error("burst_sram: ADDR_W must lie in 2..12");
      end
      if (LANE_W < 1) begin : g_bad_lane_w
         $error("burst_sram: LANE_W must be at least 1");
      end
   endgenerate

   logic                  load;
   logic                  step;
   logic                  en_now;
   logic                  en_q;
   logic                  pend_q;
   acc_e                  acc;
   logic [ADDR_W-1:0]     eff_addr;
   logic [BURST_BITS-1:0] cnt_q;
   logic [DATA_W-1:0]     rdata;
   logic                  out_en_q;
   logic [LANES-1:0]      lane_n;

   assign lane_n = {lane_hi_n, lane_lo_n};

   sbr_ctrl #(.LANES(LANES)) ctrl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .host_ld_n (host_ld_n),
      .ctlr_ld_n (ctlr_ld_n),
      .burst_go_n(burst_go_n),
      .cs_n      (cs_n),
      .we_n      (we_n),
      .lane_n    (lane_n),
      .load_o    (load),
      .step_o    (step),
      .en_now_o  (en_now),
      .en_q_o    (en_q),
      .pend_q_o  (pend_q),
      .acc_o     (acc)
   );

   sbr_burst #(.ADDR_W(ADDR_W), .BURST_LINEAR(BURST_LINEAR)) burst_i (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .step  (step),
      .addr_i(addr),
      .addr_o(eff_addr),
      .cnt_o (cnt_q)
   );

   sbr_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) array_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (acc == ACC_WRITE),
      .rd     (acc == ACC_READ),
      .addr   (eff_addr),
      .lane_we(~lane_n),
      .din    (din),
      .rdata  (rdata)
   );

   // Enable state that travels with the word last read.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_en_q <= 1'b0;
      end else if (acc == ACC_READ) begin
         out_en_q <= en_now;
      end
   end

   assign dout = (!oe_n && out_en_q) ? rdata : '0;

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk
   import sbr_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  host_ld_n,
   input logic                  ctlr_ld_n,
   input logic                  burst_go_n,
   input acc_e                  acc,
   input logic                  en_q,
   input logic                  pend_q,
   input logic [BURST_BITS-1:0] cnt_q,
   input logic [ADDR_W-1:0]     eff_addr
);

   logic armed;
   logic idle_strb;

   assign idle_strb = host_ld_n & ctlr_ld_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   p_host_reads_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !host_ld_n |-> acc != ACC_WRITE);

   p_load_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_ld_n || !ctlr_ld_n) |=> cnt_q == '0);

   p_step_counts_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_strb && !burst_go_n) |=> cnt_q == $past(cnt_q) + BURST_BITS'(1));

   p_wait_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && idle_strb && burst_go_n) |-> eff_addr == $past(eff_addr));

   p_wait_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_strb && burst_go_n && !pend_q) |-> acc != ACC_WRITE);

   p_upper_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && idle_strb) |->
         eff_addr[ADDR_W-1:BURST_BITS] == $past(eff_addr[ADDR_W-1:BURST_BITS]));

   p_select_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
      idle_strb |=> en_q == $past(en_q));

endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .host_ld_n (host_ld_n),
   .ctlr_ld_n (ctlr_ld_n),
   .burst_go_n(burst_go_n),
   .acc       (acc),
   .en_q      (en_q),
   .pend_q    (pend_q),
   .cnt_q     (cnt_q),
   .eff_addr  (eff_addr)
);

// File: tb/burst_sram_tb_top.sv
module burst_sram_tb_top;

   localparam int AW = 6;
   localparam int DW = 18;

   // ctl bit order: host_ld_n ctlr_ld_n burst_go_n cs_n we_n lane_lo_n lane_hi_n oe_n
   // ek: 0 no check, 1 zero, 2 pat(ea), 3 {pat(ea2) upper lane, pat(ea) lower lane}
   typedef struct packed {
      logic [7:0]    ctl;
      logic [AW-1:0] addr;
      logic [AW-1:0] dsel;
      logic [1:0]    ek;
      logic [AW-1:0] ea;
      logic [AW-1:0] ea2;
      logic [3:0]    req;
   } vec_t;

   localparam int NV = 26;
   localparam vec_t VECS [NV] = '{
      '{8'b10100001, 6'h10, 6'h10, 2'd0, 6'h00, 6'h00, 4'd4},  // R4 controller write
      '{8'b11000001, 6'h3F, 6'h11, 2'd0, 6'h00, 6'h00, 4'd6},  // R6 step write
      '{8'b11000001, 6'h3F, 6'h12, 2'd0, 6'h00, 6'h00, 4'd6},
      '{8'b11000001, 6'h3F, 6'h13, 2'd0, 6'h00, 6'h00, 4'd6},
      '{8'b10100001, 6'h20, 6'h30, 2'd0, 6'h00, 6'h00, 4'd4},
      '{8'b10100001, 6'h21, 6'h31, 2'd0, 6'h00, 6'h00, 4'd4},
      '{8'b00100000, 6'h12, 6'h3F, 2'd2, 6'h12, 6'h00, 4'd2},  // R2 host wins, reads
      '{8'b11001110, 6'h00, 6'h00, 2'd2, 6'h13, 6'h00, 4'd6},  // R6 2^1
      '{8'b11101110, 6'h00, 6'h00, 2'd2, 6'h13, 6'h00, 4'd7},  // R7 wait state
      '{8'b11001110, 6'h00, 6'h00, 2'd2, 6'h10, 6'h00, 4'd6},  // R6 2^2
      '{8'b11001110, 6'h00, 6'h00, 2'd2, 6'h11, 6'h00, 4'd6},  // R6 2^3
      '{8'b11001110, 6'h00, 6'h00, 2'd2, 6'h12, 6'h00, 4'd8},  // R8 wrap
      '{8'b11100000, 6'h00, 6'h3F, 2'd2, 6'h12, 6'h00, 4'd7},  // R7 held write refused
      '{8'b10101110, 6'h12, 6'h00, 2'd2, 6'h12, 6'h00, 4'd7},  // R7 word unchanged
      '{8'b01101111, 6'h20, 6'h00, 2'd1, 6'h00, 6'h00, 4'd10}, // R10 oe high
      '{8'b11100011, 6'h00, 6'h20, 2'd1, 6'h00, 6'h00, 4'd3},  // R3 deferred lower write
      '{8'b10101110, 6'h20, 6'h00, 2'd3, 6'h20, 6'h30, 4'd9},  // R9 R3 lower lane only
      '{8'b10100101, 6'h21, 6'h21, 2'd0, 6'h00, 6'h00, 4'd9},  // upper lane write
      '{8'b10101110, 6'h21, 6'h00, 2'd3, 6'h31, 6'h21, 4'd9},  // R9 upper lane only
      '{8'b10110000, 6'h10, 6'h3F, 2'd0, 6'h00, 6'h00, 4'd5},  // R5 disabled load
      '{8'b11001110, 6'h00, 6'h00, 2'd1, 6'h00, 6'h00, 4'd5},  // R5 still disabled
      '{8'b10101110, 6'h10, 6'h00, 2'd2, 6'h10, 6'h00, 4'd5},  // R5 no write happened
      '{8'b11011110, 6'h00, 6'h00, 2'd2, 6'h11, 6'h00, 4'd5},  // R5 cs_n ignored mid burst
      '{8'b11111111, 6'h00, 6'h00, 2'd1, 6'h00, 6'h00, 4'd10}, // R10
      '{8'b11111110, 6'h00, 6'h00, 2'd2, 6'h11, 6'h00, 4'd10}, // R10
      '{8'b01111110, 6'h13, 6'h00, 2'd1, 6'h00, 6'h00, 4'd5}   // R5 disabled host load
   };

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] addr;
   logic          host_ld_n, ctlr_ld_n, burst_go_n, cs_n, we_n;
   logic          lane_lo_n, lane_hi_n, oe_n;
   logic [DW-1:0] din;
   logic [DW-1:0] dout;
   logic [DW-1:0] dout_lin;
   int            n_chk = 0;
   int            n_bad = 0;
   bit            done  = 1'b0;

   always #5 clk = ~clk;

   burst_sram #(.ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .addr(addr), .host_ld_n(host_ld_n),
      .ctlr_ld_n(ctlr_ld_n), .burst_go_n(burst_go_n), .cs_n(cs_n), .we_n(we_n),
      .lane_lo_n(lane_lo_n), .lane_hi_n(lane_hi_n), .oe_n(oe_n), .din(din),
      .dout(dout));

   burst_sram #(.ADDR_W(AW), .BURST_LINEAR(1'b1)) dut_lin_i (
      .clk(clk), .rst_n(rst_n), .addr(addr), .host_ld_n(host_ld_n),
      .ctlr_ld_n(ctlr_ld_n), .burst_go_n(burst_go_n), .cs_n(cs_n), .we_n(we_n),
      .lane_lo_n(lane_lo_n), .lane_hi_n(lane_hi_n), .oe_n(oe_n), .din(din),
      .dout(dout_lin));

   function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
      return {3'b101, a, 3'b010, a};
   endfunction

   task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp,
                        input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: dout=%h expected %h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [7:0] ctl, input logic [AW-1:0] a,
                        input logic [DW-1:0] d);
      {host_ld_n, ctlr_ld_n, burst_go_n, cs_n, we_n, lane_lo_n, lane_hi_n, oe_n} = ctl;
      addr = a;
      din  = d;
   endtask

   task automatic tick;
      @(posedge clk);
      #2;
   endtask

   initial begin
      rst_n = 1'b0;
      drive(8'b11111110, '0, '0);
      repeat (3) @(posedge clk);
      #2;
      check(dout, '0, "R1 during reset");
      rst_n = 1'b1;
      drive(8'b11101110, '0, '0);
      tick();
      check(dout, '0, "R1 no load since reset");

      for (int i = 0; i < NV; i++) begin
         logic [DW-1:0] exp;
         drive(VECS[i].ctl, VECS[i].addr, pat(VECS[i].dsel));
         tick();
         case (VECS[i].ek)
            2'd1:    exp = '0;
            2'd2:    exp = pat(VECS[i].ea);
            default: exp = {pat(VECS[i].ea2)[DW-1:9], pat(VECS[i].ea)[8:0]};
         endcase
         if (VECS[i].ek != 2'd0) begin
            check(dout, exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
         end
      end

      // R6 and R11: burst from base 0x11 in both orders.
      drive(8'b01101110, 6'h11, '0);
      tick();
      check(dout, pat(6'h11), "R6 xor base");
      check(dout_lin, pat(6'h11), "R11 linear base");
      drive(8'b11001110, '0, '0);
      tick();
      check(dout, pat(6'h10), "R6 xor step1");
      check(dout_lin, pat(6'h12), "R11 linear step1");
      tick();
      check(dout, pat(6'h13), "R6 xor step2");
      check(dout_lin, pat(6'h13), "R11 linear step2");
      tick();
      check(dout, pat(6'h12), "R6 xor step3");
      check(dout_lin, pat(6'h10), "R11 linear step3");

      // R1: reset mid-run clears output state but keeps stored words.
      rst_n = 1'b0;
      tick();
      rst_n = 1'b1;
      drive(8'b11101110, '0, '0);
      tick();
      check(dout, '0, "R1 after second reset");
      drive(8'b10101110, 6'h13, '0);
      tick();
      check(dout, pat(6'h13), "R1 storage kept");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R1 watchdog: run unfinished, expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule